// File: doc/BRIEF.md
# Postfix Stack Evaluator

This block holds a small stack of data words in a register file and runs four commands on it: push an input word, pop the top word to an output, and two binary operators (sum and product) that take the two topmost entries and leave one result in their place. A sequence of these commands is enough to evaluate an expression written in postfix order. Operands are pushed as they appear, and each operator symbol becomes one command.

The stack pointer counts downward. A push moves the pointer down before it writes. A pop reads at the pointer and then moves it up. The pointer rests at the depth value when the stack holds nothing. Two flags, full and empty, are updated from the pointer as each command completes.

Commands use a valid/ready handshake. One cycle after a command is accepted, a done pulse or an error pulse appears. A command that would overrun or underrun the stack is refused and leaves every piece of state as it was. The current top word is always visible on its own output.

Top module: `stack_eval`

## Requirements
- R1: After reset the stack is empty: `empty`=1, `full`=0, `top_word`=0, `done`=0, `err`=0, and `cmd_ready` is 1 from the first clock after reset is released.
- R2: A push (`cmd_op`=2'b00) moves the pointer down one place, then stores `cmd_data` at the new place. In the cycle after acceptance, `done` is 1 and `top_word` shows the pushed word.
- R3: A pop (`cmd_op`=2'b01) returns the old top word on `pop_data` with `done` one cycle after acceptance. The entry beneath then becomes `top_word`, or 0 if the stack is now empty.
- R4: `empty` is set when a pop removes the last entry, and every accepted push clears it.
- R5: `full` is set when a push fills the last of DEPTH places, and every accepted pop or operator clears it.
- R6: The sum command (`cmd_op`=2'b10) replaces the two top entries with their sum modulo 2^DATA_W. The stack then holds one entry fewer.
- R7: The product command (`cmd_op`=2'b11) replaces the two top entries with the low DATA_W bits of their product.
- R8: A push while `full` is 1 gives an `err` pulse one cycle later and no `done`. The top word and both flags stay unchanged.
- R9: A pop while `empty`, or an operator with fewer than two entries, gives an `err` pulse one cycle later. The stack contents and flags stay unchanged.
- R10: The command sequence push 3, push 4, product, push 5, push 6, product, sum leaves 42 as the only entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 00 push, 01 pop, 10 sum, 11 product |
| cmd_data | input | DATA_W | Word to push |
| done | output | 1 | Command completed, one cycle pulse |
| err | output | 1 | Command refused, one cycle pulse |
| pop_data | output | DATA_W | Word removed by the last pop |
| top_word | output | DATA_W | Current top of stack, 0 when empty |
| full | output | 1 | All places occupied |
| empty | output | 1 | No entry held |

## Verification
Every result is due exactly one cycle after the command is accepted. In that cycle `done` or `err` pulses, and `pop_data`, `top_word`, `full` and `empty` already hold their new values. The driver records, for each command, the cycle in which its outcome is due. The monitor samples on the falling edge of that cycle. A result that arrives in any other cycle is a failure, and so is a due cycle that passes with neither pulse.

// File: rtl/stack_eval.sv
module stack_eval #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] pop_data,
  output logic [DATA_W-1:0] top_word,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] SP_BASE = PTR_W'(DEPTH);
  localparam logic [1:0] OP_PUSH = 2'b00, OP_POP = 2'b01, OP_SUM = 2'b10, OP_PROD = 2'b11;

  logic [DATA_W-1:0]   stk [DEPTH];
  logic [PTR_W-1:0]    sp;
  logic [PTR_W-1:0]    sp_dn, sp_up, used;
  logic [IDX_W-1:0]    top_i, below_i, push_i;
  logic [DATA_W-1:0]   opa, opb, result;
  logic [2*DATA_W-1:0] prod;
  logic                accept, is_op, refuse, go;

  assign accept  = cmd_valid & cmd_ready;
  assign is_op   = cmd_op[1];
  assign sp_dn   = sp - 1'b1;
  assign sp_up   = sp + 1'b1;
  assign used    = SP_BASE - sp;
  assign top_i   = IDX_W'(sp);
  assign below_i = IDX_W'(sp_up);
  assign push_i  = IDX_W'(sp_dn);
  assign opa     = stk[top_i];
  assign opb     = stk[below_i];
  assign prod    = opa * opb;
  assign result  = (cmd_op == OP_PROD) ? prod[DATA_W-1:0] : opa + opb;
  assign top_word = empty ? '0 : opa;

  assign refuse = accept & (((cmd_op == OP_PUSH) & full) |
                            ((cmd_op == OP_POP) & empty) |
                            (is_op & (used < PTR_W'(2))));
  assign go = accept & ~refuse;

  always_ff @(posedge clk) begin
    if (go && cmd_op == OP_PUSH) stk[push_i] <= cmd_data;
    else if (go && is_op)        stk[below_i] <= result;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp        <= SP_BASE;
      full      <= 1'b0;
      empty     <= 1'b1;
      done      <= 1'b0;
      err       <= 1'b0;
      pop_data  <= '0;
      cmd_ready <= 1'b0;
    end else begin
      cmd_ready <= 1'b1;
      done      <= go;
      err       <= refuse;
      if (go) begin
        if (cmd_op == OP_PUSH) begin
          sp    <= sp_dn;
          full  <= (sp_dn == '0);
          empty <= 1'b0;
        end else begin
          if (cmd_op == OP_POP) pop_data <= opa;
          sp    <= sp_up;
          empty <= (sp_up == SP_BASE);
          full  <= 1'b0;
        end
      end
    end
  end

  assert_flags_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_push_moves_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_op == OP_PUSH && !full |=> done && sp == $past(sp) - 1'b1 && top_word == $past(cmd_data));

  assert_pop_returns_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_op == OP_POP && !empty |=> done && pop_data == $past(top_word));

  assert_full_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_op == OP_PUSH && full |=> err && !done && $stable(sp) && full);

  assert_underrun_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> err && $stable(sp) && $stable(top_word));

  assert_sum_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_op == OP_SUM |=> top_word == $past(opa + opb));

  assert_prod_trunc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_op == OP_PROD |=> top_word == $past(prod[DATA_W-1:0]));

  assert_pulses_apart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));
endmodule

// File: tb/stack_eval_bench.sv
module stack_eval_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DP = 8;

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [DW-1:0] cmd_data = 0;
  logic cmd_ready, done, err, full, empty;
  logic [DW-1:0] pop_data, top_word;

  stack_eval #(.DATA_W(DW), .DEPTH(DP)) u_stack_eval (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .done(done), .err(err),
    .pop_data(pop_data), .top_word(top_word), .full(full), .empty(empty));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    bit          x_err;
    bit          chk_pop;
    logic [DW-1:0] x_pop;
    logic [DW-1:0] x_tos;
    bit          x_full;
    bit          x_empty;
    string       req;
  } item_t;

  item_t q[$];
  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;
  logic [DW-1:0] mstk [DP];
  int msp = DP;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("[TB] FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: applies one command and records what the requirements predict
  task automatic issue(logic [1:0] op, logic [DW-1:0] d, string req);
    item_t it;
    logic [2*DW-1:0] p;
    @(negedge clk);
    it.req = req; it.chk_pop = 0; it.x_pop = 0; it.x_err = 0;
    case (op)
      2'b00: if (msp == 0) it.x_err = 1; else begin msp--; mstk[msp] = d; end
      2'b01: if (msp == DP) it.x_err = 1;
             else begin it.chk_pop = 1; it.x_pop = mstk[msp]; msp++; end
      default: if (DP - msp < 2) it.x_err = 1;
               else begin
                 p = mstk[msp] * mstk[msp+1];
                 mstk[msp+1] = (op == 2'b11) ? p[DW-1:0] : mstk[msp] + mstk[msp+1];
                 msp++;
               end
    endcase
    it.x_tos = (msp == DP) ? '0 : mstk[msp];
    it.x_full = (msp == 0);
    it.x_empty = (msp == DP);
    it.due = cyc + 1;
    q.push_back(it);
    cmd_valid = 1; cmd_op = op; cmd_data = d;
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  // monitor: compares every outcome in the cycle it is due
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done || err) begin
        if (q.size() == 0) begin
          tests++; fails++;
          $display("[TB] FAIL R2 unexpected pulse: actual done=%0b err=%0b expected none", done, err);
        end else begin
          item_t it;
          it = q.pop_front();
          check(it.req, "due cycle", DW'(cyc), DW'(it.due));
          check(it.req, "err", DW'(err), DW'(it.x_err));
          check(it.req, "done", DW'(done), DW'(!it.x_err));
          if (it.chk_pop) check(it.req, "pop_data", pop_data, it.x_pop);
          check(it.req, "top_word", top_word, it.x_tos);
          check(it.req, "full", DW'(full), DW'(it.x_full));
          check(it.req, "empty", DW'(empty), DW'(it.x_empty));
        end
      end else if (q.size() > 0 && q[0].due <= cyc) begin
        tests++; fails++;
        $display("[TB] FAIL %s missing result: actual none expected pulse at cycle %0d", q[0].req, q[0].due);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("[TB] FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "empty", DW'(empty), 1);
    check("R1", "full", DW'(full), 0);
    check("R1", "top_word", top_word, 0);
    check("R1", "done/err", DW'({done, err}), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "cmd_ready", DW'(cmd_ready), 1);

    // R9: underrun on empty stack and operator with one entry
    issue(2'b01, 0, "R9");
    issue(2'b10, 0, "R9");
    issue(2'b00, 16'd7, "R2");
    issue(2'b11, 0, "R9");
    issue(2'b01, 0, "R3");
    // R10: postfix evaluation giving 42
    issue(2'b00, 16'd3, "R10");
    issue(2'b00, 16'd4, "R10");
    issue(2'b11, 0, "R10");
    issue(2'b00, 16'd5, "R10");
    issue(2'b00, 16'd6, "R10");
    issue(2'b11, 0, "R10");
    issue(2'b10, 0, "R10");
    issue(2'b01, 0, "R4");
    // R6 wrap and R7 truncation
    issue(2'b00, 16'hFFFF, "R6");
    issue(2'b00, 16'h0002, "R6");
    issue(2'b10, 0, "R6");
    issue(2'b00, 16'h1234, "R7");
    issue(2'b00, 16'h0100, "R7");
    issue(2'b11, 0, "R7");
    issue(2'b01, 0, "R3");
    issue(2'b01, 0, "R4");
    // R5 / R8: fill, overflow attempt, then drain
    for (int i = 0; i < DP; i++) issue(2'b00, DW'(16'h0A00 + i), "R5");
    issue(2'b00, 16'hDEAD, "R8");
    issue(2'b01, 0, "R5");
    issue(2'b00, 16'h0BEE, "R5");
    issue(2'b10, 0, "R5");
    for (int i = 0; i < DP - 1; i++) issue(2'b01, 0, "R3");
    issue(2'b01, 0, "R9");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      tests++; fails++;
      $display("[TB] FAIL R2 outstanding: actual %0d expected 0", q.size());
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule